// File: doc/BRIEF.md
# Shared Parallel Bus Transaction Monitor

This block watches a shared parallel bus with a PCI-style handshake and never drives it. On every rising clock edge it samples the cycle-framing, initiator-ready, target-ready, stop and device-select strobes, plus the four command/byte-enable lines. From these samples it tracks the bus through idle, the address phase and the data phases, including any wait states.

It reports four kinds of event:
- the start of each transaction, with its command code;
- each data word that moves;
- a running count of words in the current transaction;
- the end of the transaction.

Handshake violations raise a sticky error flag with a three-bit cause code. The flag stays set until reset.

The monitor sits beside the bus in a simulation or emulation build. Its registered event outputs can feed a scoreboard, a trace buffer or an interrupt line. Every output changes at the same clock edge that samples the bus cycle it describes.

Top module: `pbus_mon`

## Requirements
- R1: While reset is held low, txn_start, xfer, txn_end and err are 0, err_code is 0, xfer_cnt is 0 and txn_cmd is 0.
- R2: When the bus is outside a transaction and frame_n is sampled low, that clock is an address phase. At the edge that samples it, txn_start pulses for one clock and txn_cmd loads the raw cbe_n value. txn_cmd keeps that value until the next address phase.
- R3: In a data phase, xfer pulses for one clock in every sampled clock where irdy_n and trdy_n are both low. A clock where either of them is high gives no pulse.
- R4: xfer_cnt clears to 0 at an address phase and adds one for each xfer pulse. It stops at all ones and holds its value after the transaction ends.
- R5: A data phase completes when irdy_n is low together with trdy_n low or stop_n low. If frame_n is high in that clock, txn_end pulses for one clock. A completion that happens through stop_n alone gives no xfer pulse.
- R6: An address phase may be sampled in the clock directly after a completing final data phase. It is then reported exactly like one that follows idle (fast back-to-back).
- R7: Initiator commit rule. In a data phase that has not completed, irdy_n was low in the previous clock. If irdy_n is now high, or frame_n has changed, the error code is 1.
- R8: Target commit rule. In a data phase that has not completed, trdy_n or stop_n was low in the previous clock. If any of devsel_n, trdy_n or stop_n has changed, the error code is 2.
- R9: A data-phase clock with frame_n and irdy_n both high gives error code 3. The monitor then treats the bus as idle.
- R10: irdy_n low with frame_n high while the bus is outside a transaction gives error code 4.
- R11: The first error sets err and fixes err_code until reset. If several rules break in the same clock, the code is chosen in the order 1, 2, 3, 4. Monitoring of events goes on after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Cycle framing strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| devsel_n | input | 1 | Target claim, active low |
| cbe_n | input | 4 | Command in address phase, byte enables otherwise |
| txn_start | output | 1 | One-clock pulse for an address phase |
| txn_cmd | output | 4 | Command captured at the last address phase |
| xfer | output | 1 | One-clock pulse per transferred word |
| xfer_cnt | output | 8 | Words moved in the current or last transaction |
| txn_end | output | 1 | One-clock pulse when the final data phase completes |
| err | output | 1 | Sticky protocol error flag |
| err_code | output | 3 | Cause of the first error (1 to 4), 0 when none |

## Verification
The assertions assume that every bus pin holds a defined 0 or 1 from time zero, and that the pins change only away from the rising edge. The bench meets this by starting every pin at its idle value before reset is released and by driving all inputs on the falling edge. The commit properties also assume that any violation comes from the bus and not from the monitor. For that reason, the rule-breaking sequences are kept in their own directed tests, each preceded by a reset. The legal table run therefore never sets err.

// File: rtl/pbus_mon_pkg.sv
package pbus_mon_pkg;

    localparam int CBE_W  = 4;
    localparam int CODE_W = 3;

    // Bus sample after conversion to active-high strobes.
    typedef struct packed {
        logic             frame;
        logic             irdy;
        logic             trdy;
        logic             stop;
        logic             devsel;
        logic [CBE_W-1:0] cbe;
    } bus_s;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE  = 3'd0,
        ERR_INIT  = 3'd1,
        ERR_TGT   = 3'd2,
        ERR_LAST  = 3'd3,
        ERR_STRAY = 3'd4
    } err_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/pbus_pins.sv
module pbus_pins
    import pbus_mon_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic             frame_p,
    input  logic             irdy_p,
    input  logic             trdy_p,
    input  logic             stop_p,
    input  logic             devsel_p,
    input  logic [CBE_W-1:0] cbe_p,
    output bus_s             bus
);

    logic [4:0] strobes;

    generate
        if (ACTIVE_LOW) begin : g_inv
            assign strobes = ~{frame_p, irdy_p, trdy_p, stop_p, devsel_p};
        end else begin : g_pass
            assign strobes = {frame_p, irdy_p, trdy_p, stop_p, devsel_p};
        end
    endgenerate

    // The command lines are passed through as raw pin values.
    assign bus.frame  = strobes[4];
    assign bus.irdy   = strobes[3];
    assign bus.trdy   = strobes[2];
    assign bus.stop   = strobes[1];
    assign bus.devsel = strobes[0];
    assign bus.cbe    = cbe_p;

endmodule

// File: rtl/pbus_phase.sv
module pbus_phase
    import pbus_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame,
    input  logic irdy,
    input  logic trdy,
    input  logic stop,
    output logic in_data,
    output logic start,
    output logic done,
    output logic word,
    output logic fin,
    output logic last_bad,
    output logic stray
);

    typedef struct packed {
        phase_e ph;
    } st_s;

    st_s st_d, st_q;

    always_comb begin
        in_data  = (st_q.ph == PH_DATA);
        done     = in_data && irdy && (trdy || stop);
        word     = in_data && irdy && trdy;
        fin      = done && !frame;
        last_bad = in_data && !frame && !irdy;
        start    = !in_data && frame;
        stray    = !in_data && !frame && irdy;

        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: if (frame) st_d.ph = PH_DATA;
            PH_DATA: if (fin || last_bad) st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pbus_commit.sv
module pbus_commit (
    input  logic clk,
    input  logic rst_n,
    input  logic in_data,
    input  logic done,
    input  logic frame,
    input  logic irdy,
    input  logic trdy,
    input  logic stop,
    input  logic devsel,
    output logic init_bad,
    output logic tgt_bad
);

    typedef struct packed {
        logic       hold_i;
        logic       hold_t;
        logic       frame;
        logic [2:0] tgt;
    } cm_s;

    cm_s cm_d, cm_q;

    always_comb begin
        init_bad = cm_q.hold_i && in_data && (!irdy || (frame != cm_q.frame));
        tgt_bad  = cm_q.hold_t && in_data && ({devsel, trdy, stop} != cm_q.tgt);

        // A side stays committed only while the phase it joined is open.
        cm_d.hold_i = in_data && irdy && !done;
        cm_d.hold_t = in_data && (trdy || stop) && !done;
        cm_d.frame  = frame;
        cm_d.tgt    = {devsel, trdy, stop};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cm_q <= '0;
        else        cm_q <= cm_d;
    end

endmodule

// File: rtl/pbus_mon.sv
module pbus_mon
    import pbus_mon_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    input  logic              devsel_n,
    input  logic [CBE_W-1:0]  cbe_n,
    output logic              txn_start,
    output logic [CBE_W-1:0]  txn_cmd,
    output logic              xfer,
    output logic [CNT_W-1:0]  xfer_cnt,
    output logic              txn_end,
    output logic              err,
    output logic [CODE_W-1:0] err_code
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    bus_s bus;
    logic in_data, start, done, word, fin, last_bad, stray;
    logic init_bad, tgt_bad;

    pbus_pins #(.ACTIVE_LOW(ACTIVE_LOW)) u_pins (
        .frame_p(frame_n), .irdy_p(irdy_n), .trdy_p(trdy_n),
        .stop_p(stop_n), .devsel_p(devsel_n), .cbe_p(cbe_n), .bus(bus)
    );

    pbus_phase u_phase (
        .clk(clk), .rst_n(rst_n),
        .frame(bus.frame), .irdy(bus.irdy), .trdy(bus.trdy), .stop(bus.stop),
        .in_data(in_data), .start(start), .done(done), .word(word),
        .fin(fin), .last_bad(last_bad), .stray(stray)
    );

    pbus_commit u_commit (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .done(done),
        .frame(bus.frame), .irdy(bus.irdy), .trdy(bus.trdy),
        .stop(bus.stop), .devsel(bus.devsel),
        .init_bad(init_bad), .tgt_bad(tgt_bad)
    );

    typedef struct packed {
        logic              start;
        logic [CBE_W-1:0]  cmd;
        logic              xfer;
        logic [CNT_W-1:0]  cnt;
        logic              fin;
        logic              err;
        logic [CODE_W-1:0] code;
    } out_s;

    out_s o_d, o_q;
    err_e cause;

    always_comb begin
        // Fixed priority among rules broken in the same clock.
        if (init_bad)      cause = ERR_INIT;
        else if (tgt_bad)  cause = ERR_TGT;
        else if (last_bad) cause = ERR_LAST;
        else if (stray)    cause = ERR_STRAY;
        else               cause = ERR_NONE;

        o_d       = o_q;
        o_d.start = start;
        o_d.xfer  = word;
        o_d.fin   = fin;
        if (start) begin
            o_d.cmd = bus.cbe;
            o_d.cnt = '0;
        end else if (word && (o_q.cnt != CNT_MAX)) begin
            o_d.cnt = o_q.cnt + 1'b1;
        end
        if (!o_q.err && (cause != ERR_NONE)) begin
            o_d.err  = 1'b1;
            o_d.code = cause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign txn_start = o_q.start;
    assign txn_cmd   = o_q.cmd;
    assign xfer      = o_q.xfer;
    assign xfer_cnt  = o_q.cnt;
    assign txn_end   = o_q.fin;
    assign err       = o_q.err;
    assign err_code  = o_q.code;

endmodule

// File: rtl/pbus_mon_chk.sv
module pbus_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic       irdy_n,
    input logic       trdy_n,
    input logic       txn_start,
    input logic       xfer,
    input logic       txn_end,
    input logic       err,
    input logic [2:0] err_code
);

    assert_start_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> $past(!frame_n));

    assert_xfer_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> $past(!irdy_n && !trdy_n));

    assert_end_last_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end |-> $past(frame_n && !irdy_n));

    assert_start_end_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(txn_start && txn_end));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && $stable(err_code)));

    assert_err_code_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 3'd0));

endmodule

bind pbus_mon pbus_mon_chk u_chk (.*);

// File: tb/sim_pbus_mon.sv
module sim_pbus_mon;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic       stop_n = 1'b1, devsel_n = 1'b1;
    logic [3:0] cbe_n = 4'h0;
    logic       txn_start, xfer, txn_end, err;
    logic [3:0] txn_cmd;
    logic [7:0] xfer_cnt;
    logic [2:0] err_code;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    pbus_mon u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n), .cbe_n(cbe_n),
        .txn_start(txn_start), .txn_cmd(txn_cmd), .xfer(xfer),
        .xfer_cnt(xfer_cnt), .txn_end(txn_end), .err(err), .err_code(err_code)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            total = total + 1;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Fields, MSB first: active-high F I T S D, cbe, start xfer end err,
    // error code, expected count. Expectations hold after that row's edge.
    localparam logic [23:0] VEC [0:13] = '{
        {5'b00000, 4'h0, 4'b0000, 3'd0, 8'd0},
        {5'b10000, 4'h6, 4'b1000, 3'd0, 8'd0},
        {5'b11001, 4'h0, 4'b0000, 3'd0, 8'd0},
        {5'b11101, 4'h0, 4'b0100, 3'd0, 8'd1},
        {5'b01101, 4'h0, 4'b0110, 3'd0, 8'd2},
        {5'b10000, 4'h7, 4'b1000, 3'd0, 8'd0},
        {5'b01001, 4'h0, 4'b0000, 3'd0, 8'd0},
        {5'b01101, 4'h0, 4'b0110, 3'd0, 8'd1},
        {5'b00000, 4'h0, 4'b0000, 3'd0, 8'd1},
        {5'b10000, 4'h2, 4'b1000, 3'd0, 8'd0},
        {5'b10101, 4'h0, 4'b0000, 3'd0, 8'd0},
        {5'b11101, 4'h0, 4'b0100, 3'd0, 8'd1},
        {5'b01011, 4'h0, 4'b0010, 3'd0, 8'd1},
        {5'b00000, 4'h0, 4'b0000, 3'd0, 8'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic f, i, t, s, d, input logic [3:0] c);
        frame_n = ~f; irdy_n = ~i; trdy_n = ~t; stop_n = ~s; devsel_n = ~d;
        cbe_n = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
        devsel_n = 1'b1; cbe_n = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        rst_n = 1'b0;
        step(1, 1, 1, 0, 1, 4'h9);
        check("R1 start in reset", int'(txn_start), 0);
        check("R1 xfer in reset", int'(xfer), 0);
        check("R1 err in reset", int'(err), 0);
        check("R1 count in reset", int'(xfer_cnt), 0);
        check("R1 cmd in reset", int'(txn_cmd), 0);
        do_reset();

        for (int k = 0; k < 14; k++) begin
            logic [23:0] v;
            v = VEC[k];
            step(v[23], v[22], v[21], v[20], v[19], v[18:15]);
            check("R2 txn_start", int'(txn_start), int'(v[14]));
            check("R3 xfer", int'(xfer), int'(v[13]));
            check("R5 txn_end", int'(txn_end), int'(v[12]));
            check("R4 xfer_cnt", int'(xfer_cnt), int'(v[7:0]));
            check("R7 no err on legal bus", int'(err), int'(v[11]));
            if (v[14]) check("R2 txn_cmd", int'(txn_cmd), int'(v[18:15]));
            if (k == 5) check("R6 fast back-to-back start", int'(txn_start), 1);
        end
        check("R2 cmd held", int'(txn_cmd), 2);

        // R7: initiator drops ready in an open phase
        do_reset();
        step(1, 0, 0, 0, 0, 4'h6);
        step(1, 1, 0, 0, 1, 4'h0);
        check("R7 no err yet", int'(err), 0);
        step(1, 0, 0, 0, 1, 4'h0);
        check("R7 err", int'(err), 1);
        check("R7 code", int'(err_code), 1);
        // R11: later rule break keeps first code
        step(0, 0, 0, 0, 0, 4'h0);
        check("R11 sticky code", int'(err_code), 1);
        step(1, 0, 0, 0, 0, 4'h3);
        check("R11 monitoring continues", int'(txn_start), 1);

        // R8: target drops ready while initiator waits
        do_reset();
        check("R1 err cleared", int'(err), 0);
        step(1, 0, 0, 0, 0, 4'h6);
        step(1, 0, 1, 0, 1, 4'h0);
        step(1, 0, 0, 0, 1, 4'h0);
        check("R8 trdy change code", int'(err_code), 2);

        // R8: device select change
        do_reset();
        step(1, 0, 0, 0, 0, 4'h6);
        step(1, 0, 1, 0, 1, 4'h0);
        step(1, 0, 1, 0, 0, 4'h0);
        check("R8 devsel change code", int'(err_code), 2);

        // R9: frame and ready both gone in data phase
        do_reset();
        step(1, 0, 0, 0, 0, 4'h6);
        step(0, 0, 0, 0, 0, 4'h0);
        check("R9 code", int'(err_code), 3);
        step(1, 0, 0, 0, 0, 4'h7);
        check("R9 back to idle", int'(txn_start), 1);

        // R10: ready with no transaction
        do_reset();
        step(0, 1, 0, 0, 0, 4'h0);
        check("R10 code", int'(err_code), 4);

        // R11: rules 1 and 3 in one clock, code 1 wins
        do_reset();
        step(1, 0, 0, 0, 0, 4'h6);
        step(1, 1, 0, 0, 1, 4'h0);
        step(0, 0, 0, 0, 1, 4'h0);
        check("R11 priority", int'(err_code), 1);

        // R4: count saturation, R5: stop completion
        do_reset();
        step(1, 0, 0, 0, 0, 4'h7);
        for (int n = 0; n < 260; n++) step(1, 1, 1, 0, 1, 4'h0);
        check("R4 saturate", int'(xfer_cnt), 255);
        check("R3 xfer at saturation", int'(xfer), 1);
        step(0, 1, 0, 1, 1, 4'h0);
        check("R5 stop end", int'(txn_end), 1);
        check("R5 stop no xfer", int'(xfer), 0);
        check("R4 held", int'(xfer_cnt), 255);
        check("R7 legal burst no err", int'(err), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule